// File: doc/BRIEF.md
# Embedded-Sync Video Capture into a 4:2:0 Word Ring

This block sits behind an external video decoder that delivers an 8-bit component video stream. The stream carries YCbCr 4:2:2 samples, and its line and frame timing is coded inside the bytes themselves instead of on separate sync wires. The block finds the timing codes in the stream and keeps only the bytes that fall inside active picture lines. It reduces the chroma to 4:2:0 by keeping colour bytes on every second line. The surviving bytes are packed four to a 32-bit word. Each finished word goes onto the tail of a circular queue in on-chip memory.

A downstream consumer, such as a processor or a frame encoder, watches the empty flag and takes words from the head with a single-cycle pop. The word at the head is always visible on the read port. Both queue pointers are exposed, and so are the empty, full and sticky overflow indications. A synchronous clear input empties the queue during system initialisation.

Top module: `vcap_top`

## Requirements
- R1: A timing code is the byte run FF, 00, 00, XY on consecutive valid input bytes. In XY, bit 4 selects start (0) or end (1) of active line and bit 5 flags vertical blanking. A start code with bit 5 at 0 opens capture on the next byte, and an end code closes it.
- R2: A start code that carries bit 5 at 1 opens no capture, so no word reaches the queue from that line.
- R3: The bytes of a timing code are never stored. Neither is any byte of value 00 or FF inside an active line, and such a byte does not advance the Cb, Y, Cr, Y sample position.
- R4: Kept bytes are packed in arrival order, with the first kept byte in bits 7:0 and the fourth in bits 31:24. A word is appended once its fourth byte arrives.
- R5: Active lines alternate even and odd, starting with even at the first start code after bit 5 of XY falls from 1 to 0. An even line keeps all of Cb, Y, Cr, Y. An odd line keeps only the two Y bytes of each group.
- R6: A start code discards any partly packed word left from the previous line.
- R7: The queue is empty when head equals tail, and the read port shows the word at the head. A pop while the queue is empty leaves the head unchanged.
- R8: The queue is full when it holds DEPTH-1 words. A word that arrives when the queue is full is dropped, the tail does not move, and the overflow flag sets and stays set.
- R9: Head and tail advance by one per pop or append and wrap modulo DEPTH.
- R10: Clear sets head and tail to 0 and drops the overflow flag. It takes priority over a pop and an append in the same cycle.
- R11: After reset the queue is empty and not full, the overflow flag is low, and both pointers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | A video byte is presented this cycle |
| pix_byte | input | 8 | Video stream byte |
| pop | input | 1 | Remove the word at the head |
| clear | input | 1 | Empty the queue and drop overflow |
| rd_data | output | 32 | Word at the head of the queue |
| empty | output | 1 | Queue holds no words |
| full | output | 1 | Queue holds DEPTH-1 words |
| overflow | output | 1 | Sticky flag: a word was dropped because the queue was full |
| head_ptr | output | $clog2(DEPTH) | Read pointer |
| tail_ptr | output | $clog2(DEPTH) | Write pointer |

## Verification
Some rules are checked by assertions on every cycle:
- The tail is frozen while the queue is full.
- The overflow flag stays set until a clear.
- A pop into an empty queue does not move the head.
- A clear leaves the queue at its origin.
- A blanking start code never opens capture.
- The line parity returns to even at the blanking falling edge.
- Emitted words leave the byte packer empty.

Only the bench scenarios can show the rest. These are the exact byte order and chroma selection inside each packed word across alternating lines, the loss of a partial word at the next start code, and the removal of reserved bytes from active lines. They also cover pointer wrap over many frames and which words survive an overflow.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    localparam logic [7:0] SYNC_ONES  = 8'hFF;
    localparam logic [7:0] SYNC_ZEROS = 8'h00;

    typedef struct packed {
        logic vblank;
        logic line_end;
    } tcode_t;

    typedef enum logic [1:0] {
        PH_CB = 2'd0,
        PH_Y0 = 2'd1,
        PH_CR = 2'd2,
        PH_Y1 = 2'd3
    } phase_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } sample_t;

    function automatic tcode_t decode_code(input logic [1:0] vh);
        tcode_t t;
        t.vblank   = vh[1];
        t.line_end = vh[0];
        return t;
    endfunction

    function automatic logic is_reserved(input logic [7:0] b);
        return (b == SYNC_ONES) || (b == SYNC_ZEROS);
    endfunction

endpackage

// File: rtl/vcap_trs_parser.sv
module vcap_trs_parser
    import vcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output sample_t    smp,
    output logic       sav_pulse
);

    logic [7:0] hist0_q, hist1_q, hist2_q;
    logic       active_q;
    logic       odd_line_q;
    logic       vblank_q;
    phase_e     phase_q;

    logic   code_hit;
    tcode_t code;
    logic   sample_ok;
    logic   is_chroma;

    assign code_hit  = in_valid && (hist2_q == SYNC_ONES) &&
                       (hist1_q == SYNC_ZEROS) && (hist0_q == SYNC_ZEROS);
    assign code      = decode_code(in_byte[5:4]);
    assign sample_ok = in_valid && active_q && !code_hit && !is_reserved(in_byte);
    assign is_chroma = (phase_q == PH_CB) || (phase_q == PH_CR);

    assign smp.valid = sample_ok && !(is_chroma && odd_line_q);
    assign smp.data  = in_byte;
    assign sav_pulse = code_hit && !code.line_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist0_q    <= '0;
            hist1_q    <= '0;
            hist2_q    <= '0;
            active_q   <= 1'b0;
            odd_line_q <= 1'b0;
            vblank_q   <= 1'b1;
            phase_q    <= PH_CB;
        end else if (in_valid) begin
            hist0_q <= in_byte;
            hist1_q <= hist0_q;
            hist2_q <= hist1_q;
            if (code_hit) begin
                vblank_q <= code.vblank;
                if (code.line_end) begin
                    active_q <= 1'b0;
                    if (active_q) begin
                        odd_line_q <= ~odd_line_q;
                    end
                end else begin
                    active_q <= !code.vblank;
                    phase_q  <= PH_CB;
                end
                if (vblank_q && !code.vblank) begin
                    odd_line_q <= 1'b0;
                end
            end else if (sample_ok) begin
                phase_q <= phase_e'(phase_q + 2'd1);
            end
        end
    end

    // R2: a start code inside vertical blanking never opens capture
    assert_vblank_sav_R2: assert property (@(posedge clk) disable iff (rst)
        (code_hit && !code.line_end && code.vblank) |=> !active_q);

    // R5: leaving vertical blanking restarts on an even line
    assert_parity_reset_R5: assert property (@(posedge clk) disable iff (rst)
        (code_hit && vblank_q && !code.vblank) |=> !odd_line_q);

endmodule

// File: rtl/vcap_packer.sv
module vcap_packer
    import vcap_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  sample_t           smp,
    input  logic              sav_pulse,
    output logic              wr_valid,
    output logic [WORD_W-1:0] wr_word
);

    localparam int BPW = WORD_W / 8;
    localparam int CW  = $clog2(BPW);
    localparam logic [CW-1:0] LAST = CW'(BPW - 1);

    logic [7:0]        lane_q [BPW-1];
    logic [CW-1:0]     cnt_q;
    logic [WORD_W-1:0] word_next;
    logic              wr_valid_q;
    logic [WORD_W-1:0] wr_word_q;

    for (genvar i = 0; i < BPW; i++) begin : g_lane
        if (i == BPW - 1) begin : g_last
            assign word_next[i*8 +: 8] = smp.data;
        end else begin : g_held
            assign word_next[i*8 +: 8] = lane_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            wr_valid_q <= 1'b0;
            wr_word_q  <= '0;
        end else begin
            wr_valid_q <= 1'b0;
            if (sav_pulse) begin
                cnt_q <= '0;
            end else if (smp.valid) begin
                if (cnt_q == LAST) begin
                    cnt_q      <= '0;
                    wr_valid_q <= 1'b1;
                    wr_word_q  <= word_next;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !sav_pulse && smp.valid && cnt_q != LAST) begin
            lane_q[cnt_q] <= smp.data;
        end
    end

    assign wr_valid = wr_valid_q;
    assign wr_word  = wr_word_q;

    // R4: a word leaves only when the byte collector has just been emptied
    assert_pack_empty_R4: assert property (@(posedge clk) disable iff (rst)
        wr_valid_q |-> (cnt_q == '0));

endmodule

// File: rtl/vcap_ring.sv
module vcap_ring #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              pop,
    output logic [WORD_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              overflow,
    output logic [AW-1:0]     head,
    output logic [AW-1:0]     tail
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     head_q, tail_q;
    logic              overflow_q;
    logic              do_write, do_pop;

    assign empty    = (head_q == tail_q);
    assign full     = (AW'(tail_q + 1'b1) == head_q);
    assign do_write = wr_valid && !full && !clear;
    assign do_pop   = pop && !empty && !clear;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            head_q     <= '0;
            tail_q     <= '0;
            overflow_q <= 1'b0;
        end else begin
            if (do_write) begin
                tail_q <= tail_q + 1'b1;
            end
            if (do_pop) begin
                head_q <= head_q + 1'b1;
            end
            if (wr_valid && full) begin
                overflow_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_write && !rst) begin
            mem[tail_q] <= wr_word;
        end
    end

    assign rd_data  = mem[head_q];
    assign overflow = overflow_q;
    assign head     = head_q;
    assign tail     = tail_q;

    // R8: a full queue never lets the tail move onto the head
    assert_full_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (full && !pop && !clear) |=> $stable(tail_q));

    // R8: overflow is sticky until cleared
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (overflow_q && !clear) |=> overflow_q);

    // R7: popping an empty queue has no effect on the head
    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (rst)
        (empty && !clear) |=> $stable(head_q));

    // R10: clear returns the queue to its origin
    assert_clear_origin_R10: assert property (@(posedge clk) disable iff (rst)
        clear |=> (head_q == '0 && tail_q == '0 && !overflow_q));

endmodule

// File: rtl/vcap_top.sv
module vcap_top
    import vcap_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_valid,
    input  logic [7:0]        pix_byte,
    input  logic              pop,
    input  logic              clear,
    output logic [WORD_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              overflow,
    output logic [AW-1:0]     head_ptr,
    output logic [AW-1:0]     tail_ptr
);

    sample_t           smp;
    logic              sav_pulse;
    logic              wr_valid;
    logic [WORD_W-1:0] wr_word;

    vcap_trs_parser u_parser (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (pix_valid),
        .in_byte   (pix_byte),
        .smp       (smp),
        .sav_pulse (sav_pulse)
    );

    vcap_packer #(.WORD_W(WORD_W)) u_packer (
        .clk       (clk),
        .rst       (rst),
        .smp       (smp),
        .sav_pulse (sav_pulse),
        .wr_valid  (wr_valid),
        .wr_word   (wr_word)
    );

    vcap_ring #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .wr_valid (wr_valid),
        .wr_word  (wr_word),
        .pop      (pop),
        .rd_data  (rd_data),
        .empty    (empty),
        .full     (full),
        .overflow (overflow),
        .head     (head_ptr),
        .tail     (tail_ptr)
    );

endmodule

// File: tb/vcap_top_bench.sv
module vcap_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int AW         = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pix_valid = 1'b0;
    logic [7:0]    pix_byte = '0;
    logic          pop = 1'b0;
    logic          clear = 1'b0;
    logic [31:0]   rd_data;
    logic          empty, full, overflow;
    logic [AW-1:0] head_ptr, tail_ptr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    logic [7:0]  acc [4];
    int          acc_n = 0;
    int          line_idx = 0;
    int          written = 0;

    vcap_top #(.DEPTH(DEPTH)) u_vcap_top (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_byte(pix_byte),
        .pop(pop), .clear(clear), .rd_data(rd_data), .empty(empty),
        .full(full), .overflow(overflow), .head_ptr(head_ptr), .tail_ptr(tail_ptr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rnd_sample();
        return 8'($urandom_range(254, 1));
    endfunction

    task automatic model_byte(input logic [7:0] b);
        acc[acc_n] = b;
        acc_n++;
        if (acc_n == 4) begin
            exp_q.push_back({acc[3], acc[2], acc[1], acc[0]});
            acc_n = 0;
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        pix_valid = 1'b1;
        pix_byte  = b;
    endtask

    task automatic code(input bit v, input bit h);
        put(8'hFF); put(8'h00); put(8'h00);
        put({1'b1, 1'b0, v, h, 4'h0});
    endtask

    task automatic settle();
        @(negedge clk);
        pix_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_start();
        code(1'b1, 1'b1);
        put(8'h80); put(8'h10);
        code(1'b1, 1'b0);
        for (int i = 0; i < 4; i++) put(rnd_sample());
        code(1'b1, 1'b1);
        line_idx = 0;
    endtask

    task automatic send_line(input int groups, input bit inject);
        logic [7:0] cb, y0, cr, y1;
        code(1'b0, 1'b0);
        acc_n = 0;
        for (int g = 0; g < groups; g++) begin
            cb = rnd_sample(); y0 = rnd_sample(); cr = rnd_sample(); y1 = rnd_sample();
            put(cb);
            if (inject && g == 0) put(8'h00);
            put(y0);
            if (inject && g == 0) put(8'hFF);
            put(cr); put(y1);
            if (line_idx % 2 == 0) begin
                model_byte(cb); model_byte(y0); model_byte(cr); model_byte(y1);
            end else begin
                model_byte(y0); model_byte(y1);
            end
        end
        code(1'b0, 1'b1);
        put(8'h80); put(8'h10);
        line_idx++;
    endtask

    task automatic drain(input string tag);
        int n;
        n = (exp_q.size() > DEPTH - 1) ? DEPTH - 1 : exp_q.size();
        check(AW'(tail_ptr - head_ptr) == AW'(n), {tag, " occupancy"},
              32'(AW'(tail_ptr - head_ptr)), 32'(n));
        for (int i = 0; i < n; i++) begin
            check(!empty && rd_data == exp_q[i], {tag, " word"}, rd_data, exp_q[i]);
            pop = 1'b1;
            @(negedge clk);
            pop = 1'b0;
        end
        check(empty == 1'b1, "R7 empty after drain", 32'(empty), 32'd1);
        written += n;
        check(tail_ptr == AW'(written), "R9 tail wrap", 32'(tail_ptr), 32'(AW'(written)));
        exp_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(empty && !full && !overflow, "R11 flags", {29'd0, empty, full, overflow}, 32'h4);
        check(head_ptr == 0 && tail_ptr == 0, "R11 pointers", 32'({head_ptr, tail_ptr}), 32'd0);

        // R7 pop on empty queue
        pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk);
        check(head_ptr == 0 && empty, "R7 pop when empty", 32'(head_ptr), 32'd0);

        // R2 start code in blanking captures nothing
        code(1'b1, 1'b0);
        for (int i = 0; i < 16; i++) put(rnd_sample());
        code(1'b1, 1'b1);
        settle();
        check(empty == 1'b1, "R2 blanking line ignored", 32'(tail_ptr), 32'(head_ptr));

        // R1 R3 R4 R5 R9 random frames, some with reserved bytes
        for (int f = 0; f < 12; f++) begin
            frame_start();
            for (int l = 0; l < 3; l++) begin
                send_line(2 * $urandom_range(2, 1), ($urandom_range(1, 0) == 1));
            end
            settle();
            drain("R1 R3 R4 R5");
        end

        // R6 partial word at line end is lost
        frame_start();
        send_line(2, 1'b0);
        send_line(1, 1'b0);
        send_line(1, 1'b0);
        settle();
        drain("R6 partial word");

        // R8 overflow
        frame_start();
        send_line(20, 1'b0);
        settle();
        check(full && overflow, "R8 full and overflow", {30'd0, full, overflow}, 32'h3);
        drain("R8 kept words");
        check(overflow == 1'b1, "R8 overflow sticky", 32'(overflow), 32'd1);

        // R10 clear with pop in the same cycle
        frame_start();
        send_line(2, 1'b0);
        settle();
        check(!empty, "R10 data before clear", 32'(empty), 32'd0);
        clear = 1'b1; pop = 1'b1;
        @(negedge clk);
        clear = 1'b0; pop = 1'b0;
        @(negedge clk);
        check(empty && !overflow && head_ptr == 0 && tail_ptr == 0, "R10 clear",
              {head_ptr, tail_ptr, 22'd0, overflow, empty}, 32'h1);
        exp_q.delete();
        written = 0;

        // R9 pointers after clear continue cleanly
        frame_start();
        send_line(4, 1'b0);
        settle();
        drain("R9 after clear");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule